// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a port I/O access of 1, 2 or 4 bytes may go ahead. The decision comes from the permission bitmap held inside a task-state segment. A caller pulses `start` with a port number and an access width. It also presents the task-register descriptor: the present flag, the 4-bit type, the base and the limit.

The block first checks the descriptor. If the descriptor is acceptable, the block makes up to two 16-bit reads through a request/response memory port. The first read fetches the offset of the bitmap from a fixed place in the segment. The second read fetches the two bitmap bytes that cover the port. At the end, `done` pulses for one cycle. If `fault` is high on that cycle, the access is refused with a general-protection fault and error code 0. If `fault` is low, the access is allowed.

The memory request side is valid/ready. The block raises `rd_req_valid` with `rd_addr` and holds both steady until the cycle in which `rd_req_ready` is high; that cycle completes the transfer. Any stall on `rd_req_ready` simply stretches the check. The response side has no back-pressure. The block takes `rd_rsp_data` on the first cycle with `rd_rsp_valid` high after its request has been accepted. It has exactly one read outstanding at a time.

Top module: `io_permit_checker`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fault` and `rd_req_valid` are all low.
- R2: If the descriptor is not present, or its type is not 9, or its limit is below 103, the check faults without issuing any memory read.
- R3: The first read goes to segment base + 0x66. The returned 16-bit word is little-endian: bits 7:0 come from the lower byte address. That word is the bitmap offset.
- R4: The byte offset equals the bitmap offset plus port[15:3]. If the byte offset + 1 is greater than the segment limit, the check faults after that single read, with no second read.
- R5: Otherwise the second read goes to segment base + byte offset. The word is shifted right by port[2:0]. The access is allowed only if the lowest `size` bits of the result are all zero; otherwise it faults.
- R6: `done` is high for exactly one cycle per check. `fault` is only ever high together with `done`, and `err_code` reads 0 whenever `fault` is high.
- R7: `rd_addr` stays stable while `rd_req_valid` is high and `rd_req_ready` is low. A `rd_rsp_valid` pulse that arrives while no read is outstanding is ignored.
- R8: Port, size and descriptor are captured on the accepted `start`. A `start` while `busy` is high is ignored, and the inputs may change during a check without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (accepted only while idle) |
| port | input | 16 | I/O port number |
| size | input | 3 | Access width in bytes (1, 2 or 4) |
| seg_present | input | 1 | Descriptor present flag |
| seg_type | input | 4 | Descriptor type field |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 32 | Segment limit |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Byte address of 16-bit read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 16 | Read data, little-endian |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access refused (valid with done) |
| err_code | output | 16 | Fault error code (zero) |

## Verification
The bench sweeps every descriptor type with the limit on either side of 103. It counts the reads issued for each check, so a gate that still fetches the bitmap offset from a bad segment is reported.

A sweep of 256 ports at each access width catches the following faults:
- a wrong shift amount;
- a mask that is one bit too narrow or too wide;
- swapped byte lanes, which matter when a bit run crosses into the upper byte.

The limit is placed at, just below, and just above the byte offset + 1. This exposes an off-by-one in the bounds compare, which would allow or refuse exactly one boundary port wrongly.

Throughout, the bench does three more things:
- it throttles `rd_req_ready` and injects stray response pulses, so a design that accepts data before its request is taken picks up junk;
- it scrambles the inputs mid-check;
- it fires extra `start` pulses while busy.

// File: rtl/io_permit_pkg.sv
package io_permit_pkg;
  localparam logic [7:0] MAP_PTR_OFS  = 8'h66;
  localparam logic [3:0] TSS_TYPE_OK  = 4'd9;
  localparam int unsigned TSS_MIN_LIM = 103;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE_REQ,
    ST_BASE_WAIT,
    ST_MAP_REQ,
    ST_MAP_WAIT,
    ST_DONE
  } chk_state_e;
endpackage

// File: rtl/tss_desc_gate.sv
module tss_desc_gate #(
  parameter int ADDR_W = 32
) (
  input  logic              present,
  input  logic [3:0]        seg_type,
  input  logic [ADDR_W-1:0] limit,
  output logic              usable
);
  import io_permit_pkg::*;
  always_comb begin
    usable = present && (seg_type == TSS_TYPE_OK) &&
             (limit >= ADDR_W'(TSS_MIN_LIM));
  end
endmodule

// File: rtl/iomap_bounds.sv
module iomap_bounds #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] map_ptr,
  input  logic [PORT_W-1:0] port,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] byte_off,
  output logic              in_range
);
  localparam int EXT_W = ADDR_W + 1;
  logic [EXT_W-1:0] sum_ext;
  logic [EXT_W-1:0] last_ext;
  always_comb begin
    sum_ext  = EXT_W'(map_ptr) + EXT_W'(port >> 3);
    last_ext = sum_ext + EXT_W'(1);
    byte_off = sum_ext[ADDR_W-1:0];
    in_range = (last_ext <= EXT_W'(limit));
  end
endmodule

// File: rtl/iomap_bit_test.sv
module iomap_bit_test #(
  parameter int WORD_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic [WORD_W-1:0] map_word,
  input  logic [2:0]        bit_sel,
  input  logic [SIZE_W-1:0] size,
  output logic              deny
);
  localparam int MAX_RUN = (1 << SIZE_W) - 1;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] run_mask;
  always_comb begin
    shifted = map_word >> bit_sel;
  end
  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    if (i < MAX_RUN) begin : g_live
      assign run_mask[i] = (SIZE_W'(i) < size);
    end else begin : g_dead
      assign run_mask[i] = 1'b0;
    end
  end
  always_comb begin
    deny = |(shifted & run_mask);
  end
endmodule

// File: rtl/io_permit_checker.sv
module io_permit_checker #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int WORD_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       port,
  input  logic [2:0]        size,
  input  logic              seg_present,
  input  logic [3:0]        seg_type,
  input  logic [31:0]       seg_base,
  input  logic [31:0]       seg_limit,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [15:0]       rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [15:0]       err_code
);
  import io_permit_pkg::*;

  chk_state_e        state_q;
  logic [PORT_W-1:0] port_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;
  logic [ADDR_W-1:0] off_q;
  logic              fault_q;

  logic              desc_ok;
  logic [ADDR_W-1:0] off_calc;
  logic              off_ok;
  logic              map_deny;

  tss_desc_gate #(.ADDR_W(ADDR_W)) u_gate (
    .present  (seg_present),
    .seg_type (seg_type),
    .limit    (seg_limit),
    .usable   (desc_ok)
  );

  iomap_bounds #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .WORD_W(WORD_W)) u_bounds (
    .map_ptr  (rd_rsp_data),
    .port     (port_q),
    .limit    (limit_q),
    .byte_off (off_calc),
    .in_range (off_ok)
  );

  iomap_bit_test #(.WORD_W(WORD_W), .SIZE_W(SIZE_W)) u_bits (
    .map_word (rd_rsp_data),
    .bit_sel  (port_q[2:0]),
    .size     (size_q),
    .deny     (map_deny)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      size_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
      off_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            port_q  <= port;
            size_q  <= size;
            base_q  <= seg_base;
            limit_q <= seg_limit;
            fault_q <= !desc_ok;
            state_q <= desc_ok ? ST_BASE_REQ : ST_DONE;
          end
        end
        ST_BASE_REQ: if (rd_req_ready) state_q <= ST_BASE_WAIT;
        ST_BASE_WAIT: begin
          if (rd_rsp_valid) begin
            off_q   <= off_calc;
            fault_q <= !off_ok;
            state_q <= off_ok ? ST_MAP_REQ : ST_DONE;
          end
        end
        ST_MAP_REQ: if (rd_req_ready) state_q <= ST_MAP_WAIT;
        ST_MAP_WAIT: begin
          if (rd_rsp_valid) begin
            fault_q <= map_deny;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req_valid = (state_q == ST_BASE_REQ) || (state_q == ST_MAP_REQ);
    rd_addr      = (state_q == ST_BASE_REQ) ? base_q + ADDR_W'(MAP_PTR_OFS)
                                            : base_q + off_q;
    busy         = (state_q != ST_IDLE);
    done         = (state_q == ST_DONE);
    fault        = done && fault_q;
    err_code     = '0;
  end
endmodule

// File: rtl/io_permit_checker_sva.sv
module io_permit_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_addr,
  input logic        busy,
  input logic        done,
  input logic        fault
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !done));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r8_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

bind io_permit_checker io_permit_checker_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_addr      (rd_addr),
  .busy         (busy),
  .done         (done),
  .fault        (fault)
);

// File: tb/io_permit_checker_test.sv
module io_permit_checker_test;
  localparam logic [31:0] TSS_BASE = 32'h0000_1000;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] port = '0;
  logic [2:0]  size = '0;
  logic        seg_present = 1'b0;
  logic [3:0]  seg_type = '0;
  logic [31:0] seg_base = '0;
  logic [31:0] seg_limit = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [15:0] rd_rsp_data = '0;
  logic        busy, done, fault;
  logic [15:0] err_code;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  logic [15:0] iob_cur = 16'h0068;
  int          nreads = 0;
  logic [31:0] addr_log [2];
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  io_permit_checker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .port(port), .size(size),
    .seg_present(seg_present), .seg_type(seg_type), .seg_base(seg_base),
    .seg_limit(seg_limit), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .done(done), .fault(fault), .err_code(err_code)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [7:0] b;
    b = (a[7:0] * 8'd37) ^ a[12:5];
    if (a[1:0] == 2'b01) b = 8'h00;
    if (a[3:2] == 2'b10) b = b & 8'h81;
    if (a == TSS_BASE + 32'h66) b = iob_cur[7:0];
    if (a == TSS_BASE + 32'h67) b = iob_cur[15:8];
    return b;
  endfunction

  // Memory model: accept on ready, answer one cycle later, stray pulses otherwise
  initial begin
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = 16'hFFFF;
      if (pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = {mbyte(pend_addr + 32'd1), mbyte(pend_addr)};
        pend = 1'b0;
      end else if (cycle % 5 == 0) begin
        rd_rsp_valid = 1'b1;
      end
      rd_req_ready = (cycle % 3 != 1);
      if (rd_req_valid && rd_req_ready && rst_n) begin
        pend = 1'b1;
        pend_addr = rd_addr;
        if (nreads < 2) addr_log[nreads] = rd_addr;
        nreads++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [15:0] p, input logic [2:0] sz,
                         input logic pres, input logic [3:0] ty,
                         input logic [31:0] lim, input logic [15:0] iob);
    int   exp_reads;
    bit   exp_fault;
    logic [16:0] off;
    logic [15:0] w;
    bit   got;
    int   it;
    iob_cur = iob;
    off = 17'(iob) + 17'(p >> 3);
    if (!(pres && ty == 4'd9 && lim >= 32'd103)) begin
      exp_fault = 1; exp_reads = 0;
    end else if (32'(off) + 32'd1 > lim) begin
      exp_fault = 1; exp_reads = 1;
    end else begin
      w = {mbyte(TSS_BASE + 32'(off) + 32'd1), mbyte(TSS_BASE + 32'(off))};
      w = w >> p[2:0];
      exp_fault = ((w & ((16'd1 << sz) - 16'd1)) != 16'd0);
      exp_reads = 2;
    end
    @(negedge clk);
    nreads = 0;
    port = p; size = sz; seg_present = pres; seg_type = ty;
    seg_base = TSS_BASE; seg_limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: scramble inputs after capture
    port = ~p; size = 3'd7; seg_present = ~pres; seg_type = ~ty;
    seg_base = 32'hDEAD_0000; seg_limit = 32'd5;
    got = 0;
    it = 0;
    while (!done && it < 200) begin
      start = (it == 1);  // R8: start while busy must be ignored
      @(negedge clk);
      it++;
    end
    start = 1'b0;
    got = fault;
    chk(done, "R6", "done seen", longint'(done), 1);
    chk(got == exp_fault, (exp_reads == 2) ? "R5" : (exp_reads == 1 ? "R4" : "R2"),
        $sformatf("fault port=%0h size=%0d", p, sz), longint'(got), longint'(exp_fault));
    chk(nreads == exp_reads, exp_reads == 0 ? "R2" : "R4", "read count",
        longint'(nreads), longint'(exp_reads));
    if (got) chk(err_code == 16'h0, "R6", "err_code", longint'(err_code), 0);
    if (exp_reads >= 1)
      chk(addr_log[0] == TSS_BASE + 32'h66, "R3", "first read addr",
          longint'(addr_log[0]), longint'(TSS_BASE + 32'h66));
    if (exp_reads == 2)
      chk(addr_log[1] == TSS_BASE + 32'(off), "R5", "second read addr",
          longint'(addr_log[1]), longint'(TSS_BASE + 32'(off)));
    @(negedge clk);
    chk(!done && !busy, "R6", "single-cycle done", longint'({done, busy}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !rd_req_valid, "R1", "reset state",
        longint'({busy, done, fault, rd_req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req_valid, "R1", "idle after reset",
        longint'({busy, rd_req_valid}), 0);
    // R2: descriptor gate sweep
    for (int pr = 0; pr < 2; pr++)
      for (int t = 0; t < 16; t++)
        for (int l = 102; l < 104; l++)
          run_one(16'h0003, 3'd1, 1'(pr), 4'(t), 32'(l), 16'h0068);
    // R5 / R3 / R7: port sweep at each width
    for (int p = 0; p < 256; p++) begin
      run_one(16'(p), 3'd1, 1'b1, 4'd9, 32'h2000, 16'h0068);
      run_one(16'(p), 3'd2, 1'b1, 4'd9, 32'h2000, 16'h0068);
      run_one(16'(p), 3'd4, 1'b1, 4'd9, 32'h2000, 16'h0068);
    end
    // R4: bounds around offset + 1
    for (int k = 0; k < 6; k++) begin
      logic [15:0] pp;
      logic [31:0] last;
      pp = 16'(k * 97 + 5);
      last = 32'h100 + 32'(pp >> 3) + 32'd1;
      run_one(pp, 3'd2, 1'b1, 4'd9, last - 32'd1, 16'h0100);
      run_one(pp, 3'd2, 1'b1, 4'd9, last, 16'h0100);
      run_one(pp, 3'd2, 1'b1, 4'd9, last + 32'd1, 16'h0100);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycle >= WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycle, WATCHDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule